// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage with Fork Output

This block is a drop-in replacement for an ordinary register stage in a latency-insensitive pipeline. The upstream channel and each downstream channel use a valid/stop handshake. A word moves across a channel in a cycle where that channel's valid is high and its stop is low. The stage stores up to two words in two single-word slots. Slot 0 is the input-side (master) slot and slot 1 is the second (slave) slot. A read pointer and a write pointer alternate between the two slots, so words leave in the order they arrived.

A three-state occupancy controller (empty, half, full) drives the upstream stop and the downstream valids. The stage can present its head word to several consumers, two by default. Each consumer takes the word at its own pace. The stage keeps the word until every branch has taken it, and only then moves to the next word.

Top module: `elastic_buffer`

## Requirements
- R1: A synchronous active-high `rst` puts the stage in the empty state: after the reset edge `inStop` is low and every bit of `outValid` is low.
- R2: When the stage is empty and `inValid` is high, the word on `inData` is captured. On the next cycle every `outValid` bit is high and `outData` equals that word.
- R3: `inStop` is high exactly when two words are stored. With one word stored it stays low, so one more word can still be accepted.
- R4: When one word is stored and a new word is accepted while the head word does not leave, the stage becomes full and raises `inStop` on the next cycle.
- R5: Words leave in the order they were accepted.
- R6: When one word is stored, a new word is accepted, and the head word leaves in the same cycle, the occupancy stays at one. `inStop` stays low and the new word becomes the head.
- R7: While no word is stored, every `outValid` bit is low. `outData` is then don't-care.
- R8: When branch k accepts the head word (`outValid[k]` high, `outStop[k]` low) and another branch is stalled, branch k's valid drops on the next cycle. The stalled branch keeps seeing the same word with its valid high until it accepts.
- R9: Once every branch has taken the head word, the per-branch completion flags clear. The next stored word is offered on all branches.
- R10: If all branches that still owe the word accept it in the same cycle, the word leaves in that cycle.
- R11: While the stage is full, `inValid` has no effect: the stored words and their order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for storage and controller |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Upstream offers a word |
| inStop | output | 1 | Stage refuses a word this cycle |
| inData | input | WIDTH | Upstream word |
| outValid | output | NUM_OUT | Head word offered to branch k |
| outStop | input | NUM_OUT | Branch k stalls |
| outData | output | WIDTH | Head word, shared by all branches |

## Verification
The bench builds the stage with two branches and an 8-bit word. With this configuration every occupancy state can be combined with every mix of upstream offer and per-branch stall, and every pattern of completion flags can arise. A long pseudo-random sweep over the three handshake inputs runs the stage through all of these combinations and compares every output against an arithmetic queue model in every cycle. Directed sequences come first. They cover filling to full, same-cycle push and pop at one word, and a branch that accepts while the other stalls.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic [1:0] {OCC_EMPTY = 2'd0, OCC_HALF = 2'd1, OCC_FULL = 2'd2} occ_e;

  typedef struct packed {
    logic wrEn;
    logic wrSlot;
    logic rdSlot;
  } ebStrobe_t;
endpackage

// File: rtl/eb_datapath.sv
module eb_datapath #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  eb_pkg::ebStrobe_t strobe,
  input  logic [WIDTH-1:0]  inData,
  output logic [WIDTH-1:0]  outData
);
  localparam int SLOTS = 2;

  logic [WIDTH-1:0] slotQ [SLOTS];

  // Slot 0 is the master half, slot 1 the slave half.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (int'(strobe.wrSlot) == s)) slotQ[s] <= inData;
    end
  end

  assign outData = slotQ[strobe.rdSlot];
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              pop,
  output logic              inStop,
  output logic              headValid,
  output eb_pkg::occ_e      occ,
  output eb_pkg::ebStrobe_t strobe
);
  import eb_pkg::*;

  occ_e occNext;
  logic wrPtr, rdPtr, accept;

  assign inStop    = (occ == OCC_FULL);
  assign headValid = (occ != OCC_EMPTY);
  assign accept    = inValid && !inStop;

  always_comb begin
    occNext = occ;
    unique case (occ)
      OCC_EMPTY: if (accept) occNext = OCC_HALF;
      OCC_HALF: begin
        if (accept && !pop)      occNext = OCC_FULL;
        else if (!accept && pop) occNext = OCC_EMPTY;
      end
      OCC_FULL: if (pop) occNext = OCC_HALF;
      default:  occNext = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= OCC_EMPTY;
      wrPtr <= 1'b0;
      rdPtr <= 1'b0;
    end else begin
      occ <= occNext;
      if (accept) wrPtr <= ~wrPtr;
      if (pop)    rdPtr <= ~rdPtr;
    end
  end

  assign strobe.wrEn   = accept;
  assign strobe.wrSlot = wrPtr;
  assign strobe.rdSlot = rdPtr;
endmodule

// File: rtl/eb_fork.sv
module eb_fork #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               headValid,
  input  logic [NUM_OUT-1:0] outStop,
  output logic [NUM_OUT-1:0] outValid,
  output logic               pop
);
  logic [NUM_OUT-1:0] doneQ, xfer;

  assign pop = headValid && (&(doneQ | xfer));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_branch
    assign outValid[k] = headValid && !doneQ[k];
    assign xfer[k]     = outValid[k] && !outStop[k];
    always_ff @(posedge clk) begin
      if (rst || pop) doneQ[k] <= 1'b0;
      else if (xfer[k]) doneQ[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/elastic_buffer.sv
module elastic_buffer #(
  parameter int WIDTH   = 8,
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inStop,
  input  logic [WIDTH-1:0]   inData,
  output logic [NUM_OUT-1:0] outValid,
  input  logic [NUM_OUT-1:0] outStop,
  output logic [WIDTH-1:0]   outData
);
  eb_pkg::ebStrobe_t strobe;
  eb_pkg::occ_e      occ;
  logic              headValid, pop;

  eb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .pop(pop),
    .inStop(inStop), .headValid(headValid), .occ(occ), .strobe(strobe)
  );

  eb_fork #(.NUM_OUT(NUM_OUT)) u_fork (
    .clk(clk), .rst(rst), .headValid(headValid), .outStop(outStop),
    .outValid(outValid), .pop(pop)
  );

  eb_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobe(strobe), .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int WIDTH   = 8,
  parameter int NUM_OUT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               inStop,
  input logic [NUM_OUT-1:0] outValid,
  input logic [NUM_OUT-1:0] outStop,
  input logic [WIDTH-1:0]   outData,
  input eb_pkg::occ_e       occ,
  input logic               pop
);
  import eb_pkg::*;

  // R1: reset leaves stage empty and silent
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (outValid == '0) && !inStop);

  // R7: no token, no valid
  a_r7_empty_invalid: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_EMPTY) |-> (outValid == '0));

  // R4: one stored, push without pop fills
  a_r4_fill: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_HALF) && inValid && !pop |=> inStop);

  // R6: one stored, push and pop keep one
  a_r6_half_steady: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_HALF) && inValid && pop |=> (occ == OCC_HALF) && !inStop);

  // R11: full and nothing leaves -> nothing changes
  a_r11_full_hold: assert property (@(posedge clk) disable iff (rst)
    inStop && !pop |=> inStop && $stable(outData));

  // R8: a stalled branch keeps its word
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_br
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
      outValid[k] && outStop[k] |=> outValid[k] && $stable(outData));
  end
endmodule

bind elastic_buffer eb_checker #(.WIDTH(WIDTH), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inStop(inStop),
  .outValid(outValid), .outStop(outStop), .outData(outData),
  .occ(occ), .pop(pop)
);

// File: tb/elastic_buffer_test.sv
module elastic_buffer_test;
  localparam int W = 8;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inStop;
  logic [W-1:0] inData = '0;
  logic [N-1:0] outValid;
  logic [N-1:0] outStop = '0;
  logic [W-1:0] outData;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // queue model
  int           mCnt = 0;
  logic [W-1:0] mQ [2];
  logic [N-1:0] mDone = '0;

  always #2 clk = ~clk;

  elastic_buffer #(.WIDTH(W), .NUM_OUT(N)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inStop(inStop), .inData(inData),
    .outValid(outValid), .outStop(outStop), .outData(outData)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check outputs vs model, then advance model at posedge
  task automatic step(string tag, logic v, logic [W-1:0] d, logic [N-1:0] s);
    logic [N-1:0] xf, expV;
    logic acc, popM;
    @(negedge clk);
    inValid = v; inData = d; outStop = s;
    #1;
    expV = (mCnt > 0) ? ~mDone : '0;
    chk({tag, " R3 inStop"}, W'(inStop), W'(mCnt == 2));
    chk({tag, " R7/R8 outValid"}, W'(outValid), W'(expV));
    if (mCnt > 0) chk({tag, " R5 outData"}, outData, mQ[0]);
    acc  = v && (mCnt < 2);
    xf   = expV & ~s;
    popM = (mCnt > 0) && (&(mDone | xf));
    @(posedge clk);
    if (popM) begin mQ[0] = mQ[1]; mCnt--; end
    if (acc) begin mQ[mCnt] = d; mCnt++; end
    mDone = popM ? '0 : (mDone | xf);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset inStop", W'(inStop), '0);
    chk("R1 reset outValid", W'(outValid), '0);

    // R2 empty capture, then R4 fill to full
    step("R2", 1, 8'hA1, 2'b11);
    step("R4", 1, 8'hB2, 2'b11);
    // R11 full: offer ignored
    step("R11", 1, 8'hEE, 2'b11);
    step("R11", 1, 8'hEF, 2'b11);
    // R8 branch 0 takes, branch 1 stalls
    step("R8", 0, 8'h00, 2'b10);
    step("R8", 0, 8'h00, 2'b10);
    // R9 branch 1 finishes, flags clear, B2 on both
    step("R9", 0, 8'h00, 2'b00);
    // R10 both accept in one cycle while R6 push at half
    step("R6", 1, 8'hC3, 2'b00);
    step("R5", 0, 8'h00, 2'b11);
    step("R10", 0, 8'h00, 2'b00);
    step("R7", 0, 8'h00, 2'b00);

    // near-exhaustive sweep of handshake inputs
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step("sweep", lfsr[0] | lfsr[5], lfsr[15:8], {lfsr[3] & lfsr[7], lfsr[2] & lfsr[9]});
      end
    end

    // R1 again: reset mid-traffic
    @(negedge clk); rst = 1'b1; inValid = 1'b1;
    @(posedge clk); #1;
    chk("R1 re-reset inStop", W'(inStop), '0);
    chk("R1 re-reset outValid", W'(outValid), '0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule